// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block lets on-chip logic read and program a small serial configuration EEPROM over a three-wire link: a select line, a shift clock, and one data line in each direction. A host hands over one request at a time: an operation code, a word address and a 16-bit data word for writes. The block frames the command, clocks it out, and reports completion with a one-cycle done pulse. For reads it also returns the word it sampled from the device.

Each frame opens with a zero bit. The start bit and the opcode come next, fused into one header nibble. The address follows most significant bit first, and a data field comes last where the command has one. The write-enable command has no address. Its two extra opcode bits sit at the top of the address field and the rest of that field is padded with zeros. The shift clock is the system clock divided down by a parameter. After every frame the select line is held low for a settling time. A write is then followed by a long fixed wait while the device commits the word internally. A busy flag covers the whole exchange.

Top module: `uwire_eeprom_master`

## Requirements
- R1: While reset is held and right after it, `mem_sel`, `mem_clk`, `mem_mosi`, `busy` and `done` are all 0.
- R2: A request is accepted while `busy` is 0. `busy` is 1 from the cycle after acceptance until the done cycle. `done` is high for exactly one cycle and `busy` is 0 in the next cycle.
- R3: `op`=0 (read) sends the bits 0,1,1,0 and then the ADDR_W address bits MSB first, followed by DATA_W clock pulses with `mem_mosi` at 0. That makes 4+ADDR_W+DATA_W rising edges.
- R4: `op`=1 (write) sends the bits 0,1,0,1, then the address MSB first, then `wdata` MSB first. That makes 4+ADDR_W+DATA_W rising edges.
- R5: `op`=2 or 3 (write enable) sends the bits 0,1,0,0,1,1 and then ADDR_W-2 zeros, for 4+ADDR_W rising edges in total.
- R6: On a read, `mem_miso` is sampled once in each of the last DATA_W clock pulses, at the end of the high phase, MSB first. The assembled word is on `rdata` when `done` is high.
- R7: `mem_clk` stays high for HALF_DIV system cycles and low for HALF_DIV cycles. `mem_mosi` does not change in the cycle in which `mem_clk` rises, nor while `mem_clk` stays high.
- R8: `mem_clk` is high only while `mem_sel` is high. `mem_sel` is low whenever `busy` is 0.
- R9: After the last bit of a frame, `mem_sel` is low for exactly SETTLE_CYC busy cycles before `done` on reads and enables. On writes this stretch is SETTLE_CYC+WRITE_WAIT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, taken when not busy |
| op | input | 2 | 0 read, 1 write, 2/3 write enable |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Word to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Word returned by the last read |
| mem_sel | output | 1 | Device select |
| mem_clk | output | 1 | Serial shift clock |
| mem_mosi | output | 1 | Serial data to device |
| mem_miso | input | 1 | Serial data from device |

## Verification
The bench pairs the block with a behavioural EEPROM. It first sends write enable. It then writes every one of the 64 addresses with an arithmetic pattern and reads each one back. Because every address gets a distinct word, bit-order errors and shifts of the address or data fields show up. A final pass writes all-ones, all-zeros and a pattern with only the end bits set, which separates errors at the MSB/LSB boundary from stuck data. For every frame, the bench rebuilds the exact bit stream and edge count from the operation. It also measures clock high time, data movement while the clock is high, and the select-low tail. This tells the three frame kinds apart and separates the write wait from the plain settle time.

// File: rtl/uwire_pkg.sv
// Shared types for the three-wire EEPROM master.
// Assumes: op codes and the state set are only used inside this block.
package uwire_pkg;

    typedef enum logic [1:0] {
        UW_RD     = 2'd0,
        UW_WR     = 2'd1,
        UW_EN     = 2'd2,
        UW_EN_ALT = 2'd3
    } uw_op_e;

    // Leading zero + start bit + opcode, as shifted out first.
    localparam logic [3:0] HDR_RD = 4'b0110;
    localparam logic [3:0] HDR_WR = 4'b0101;
    localparam logic [3:0] HDR_EN = 4'b0100;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LO,
        S_HI,
        S_SETTLE,
        S_WWAIT,
        S_FIN
    } uw_state_e;

endpackage

// File: rtl/uw_frame_build.sv
// Builds the outgoing bit stream (MSB first) and its length for one command.
// Assumes: ADDR_W >= 3 so that the enable command has a padding field.
module uw_frame_build
    import uwire_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int FW     = 4 + ADDR_W + DATA_W,
    parameter int LW     = $clog2(FW + 1)
) (
    input  uw_op_e              op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [FW-1:0]       frame,
    output logic [LW-1:0]       nbits
);

    localparam logic [ADDR_W-1:0] EN_FIELD = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [LW-1:0]     LEN_LONG  = LW'(FW);
    localparam logic [LW-1:0]     LEN_SHORT = LW'(4 + ADDR_W);

    // Select header, address field, data field and length for the opcode.
    always_comb begin
        unique case (op)
            UW_RD: begin
                frame = {HDR_RD, addr, {DATA_W{1'b0}}};
                nbits = LEN_LONG;
            end
            UW_WR: begin
                frame = {HDR_WR, addr, wdata};
                nbits = LEN_LONG;
            end
            default: begin
                frame = {HDR_EN, EN_FIELD, {DATA_W{1'b0}}};
                nbits = LEN_SHORT;
            end
        endcase
    end

endmodule

// File: rtl/uw_span_timer.sv
// Down-counter that times clock phases, settle time and the write wait.
// Assumes: a load of N-1 gives a span of N cycles ending when expired is seen.
module uw_span_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          expired
);

    logic [TW-1:0] cnt;

    // Reload on request, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/uw_seq.sv
// Frame sequencer: drives select, the clock and data, samples read data,
// then runs the settle time and the write wait.
// Assumes: the timer is idle (expired) when a request arrives.
module uw_seq
    import uwire_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FW         = 22,
    parameter int LW         = 5,
    parameter int TW         = 8,
    parameter int HALF_DIV   = 2,
    parameter int SETTLE_CYC = 4,
    parameter int WRITE_WAIT = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  uw_op_e            op,
    input  logic [FW-1:0]     frame,
    input  logic [LW-1:0]     nbits,
    input  logic              expired,
    output logic              t_load,
    output logic [TW-1:0]     t_val,
    input  logic              sdo,
    output logic              cs,
    output logic              sclk,
    output logic              sdi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [TW-1:0] HALF_V   = TW'(HALF_DIV - 1);
    localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] WAIT_V   = TW'(WRITE_WAIT - 1);
    localparam logic [LW-1:0] DATA_L   = LW'(DATA_W);
    localparam logic [LW-1:0] ONE_L    = LW'(1);

    uw_state_e         state;
    uw_op_e            op_q;
    logic [FW-1:0]     shreg;
    logic [LW-1:0]     left;
    logic [DATA_W-1:0] rx;
    logic              cs_q;
    logic              sclk_q;

    // Choose when and with what the span timer is reloaded.
    always_comb begin
        t_load = 1'b0;
        t_val  = HALF_V;
        unique case (state)
            S_IDLE:   t_load = req;
            S_LO:     t_load = expired;
            S_HI: begin
                t_load = expired;
                t_val  = (left == ONE_L) ? SETTLE_V : HALF_V;
            end
            S_SETTLE: begin
                t_load = expired && (op_q == UW_WR);
                t_val  = WAIT_V;
            end
            default: ;
        endcase
    end

    // Main frame state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= UW_RD;
            shreg  <= '0;
            left   <= '0;
            rx     <= '0;
            rdata  <= '0;
            cs_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req) begin
                        shreg <= frame;
                        left  <= nbits;
                        op_q  <= op;
                        cs_q  <= 1'b1;
                        state <= S_LO;
                    end
                end
                S_LO: begin
                    if (expired) begin
                        sclk_q <= 1'b1;
                        state  <= S_HI;
                    end
                end
                S_HI: begin
                    if (expired) begin
                        sclk_q <= 1'b0;
                        if ((op_q == UW_RD) && (left <= DATA_L)) begin
                            rx <= {rx[DATA_W-2:0], sdo};
                        end
                        if (left == ONE_L) begin
                            cs_q  <= 1'b0;
                            state <= S_SETTLE;
                        end else begin
                            shreg <= shreg << 1;
                            left  <= left - 1'b1;
                            state <= S_LO;
                        end
                    end
                end
                S_SETTLE: begin
                    if (expired) begin
                        if (op_q == UW_RD) begin
                            rdata <= rx;
                        end
                        state <= (op_q == UW_WR) ? S_WWAIT : S_FIN;
                    end
                end
                S_WWAIT: begin
                    if (expired) begin
                        state <= S_FIN;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign cs   = cs_q;
    assign sclk = sclk_q;
    assign sdi  = cs_q & shreg[FW-1];
    assign busy = (state != S_IDLE);
    assign done = (state == S_FIN);

endmodule

// File: rtl/uwire_eeprom_master.sv
// Top level of the three-wire EEPROM master: frame builder, sequencer, timer.
// Assumes: HALF_DIV, SETTLE_CYC, WRITE_WAIT >= 1 and ADDR_W >= 3.
module uwire_eeprom_master
    import uwire_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int HALF_DIV   = 2,
    parameter int SETTLE_CYC = 4,
    parameter int WRITE_WAIT = 1500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_sel,
    output logic              mem_clk,
    output logic              mem_mosi,
    input  logic              mem_miso
);

    localparam int FW   = 4 + ADDR_W + DATA_W;
    localparam int LW   = $clog2(FW + 1);
    localparam int TM1  = (HALF_DIV > SETTLE_CYC) ? HALF_DIV : SETTLE_CYC;
    localparam int TMAX = (TM1 > WRITE_WAIT) ? TM1 : WRITE_WAIT;
    localparam int TW   = $clog2(TMAX + 1);

    uw_op_e        op_e;
    logic [FW-1:0] frame;
    logic [LW-1:0] nbits;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          expired;

    assign op_e = uw_op_e'(op);

    uw_frame_build #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FW(FW), .LW(LW)
    ) u_build (
        .op(op_e), .addr(addr), .wdata(wdata), .frame(frame), .nbits(nbits)
    );

    uw_span_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .expired(expired)
    );

    uw_seq #(
        .DATA_W(DATA_W), .FW(FW), .LW(LW), .TW(TW), .HALF_DIV(HALF_DIV),
        .SETTLE_CYC(SETTLE_CYC), .WRITE_WAIT(WRITE_WAIT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op_e), .frame(frame),
        .nbits(nbits), .expired(expired), .t_load(t_load), .t_val(t_val),
        .sdo(mem_miso), .cs(mem_sel), .sclk(mem_clk), .sdi(mem_mosi),
        .busy(busy), .done(done), .rdata(rdata)
    );

endmodule

// File: rtl/uw_master_checker.sv
// Protocol checker for the three-wire EEPROM master, bound to the top.
// Assumes: reset is synchronous and active low.
module uw_master_checker (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic done,
    input logic mem_sel,
    input logic mem_clk,
    input logic mem_mosi
);

    // R2: an idle request starts an operation
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);

    // R2: done ends busy and is a single-cycle pulse
    a_r2_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    // R2: done only appears during an operation
    a_r2_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R7: data has setup time before the rising clock
    a_r7_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_clk) |-> $stable(mem_mosi));

    // R7: data holds while the clock stays high
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_clk && $past(mem_clk)) |-> $stable(mem_mosi));

    // R8: the clock pulses only inside a selected frame
    a_r8_clk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clk |-> mem_sel);

    // R8: the device is never selected while idle
    a_r8_idle_desel: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_sel);

endmodule

bind uwire_eeprom_master uw_master_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
    .mem_sel(mem_sel), .mem_clk(mem_clk), .mem_mosi(mem_mosi)
);

// File: tb/sim_uwire_eeprom_master.sv
module sim_uwire_eeprom_master;

    localparam int CLK_P  = 10;
    localparam int A      = 6;
    localparam int D      = 16;
    localparam int HALF   = 2;
    localparam int SETTLE = 3;
    localparam int WAITC  = 40;
    localparam int LIMIT  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [1:0]    op = 2'd0;
    logic [A-1:0]  addr = '0;
    logic [D-1:0]  wdata = '0;
    logic          busy, done;
    logic [D-1:0]  rdata;
    logic          mem_sel, mem_clk, mem_mosi;
    logic          mem_miso = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit ended = 0;
    bit timeout = 0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uwire_eeprom_master #(
        .ADDR_W(A), .DATA_W(D), .HALF_DIV(HALF),
        .SETTLE_CYC(SETTLE), .WRITE_WAIT(WAITC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
        .mem_sel(mem_sel), .mem_clk(mem_clk), .mem_mosi(mem_mosi),
        .mem_miso(mem_miso)
    );

    // Behavioural EEPROM responder
    logic [31:0]  cap = '0;
    int           ncap = 0;
    logic [31:0]  fr_bits = '0;
    int           fr_n = 0;
    logic [3:0]   cmd = '0;
    logic [A-1:0] dev_a = '0;
    logic [D-1:0] mem_arr [64];
    bit           wen = 0;

    always @(posedge mem_sel) begin
        cap = '0;
        ncap = 0;
    end

    always @(negedge mem_sel) begin
        fr_bits = cap;
        fr_n = ncap;
        mem_miso = 1'b1;
    end

    always @(posedge mem_clk) begin
        cap = {cap[30:0], mem_mosi};
        ncap = ncap + 1;
        if (ncap == 4) cmd = cap[3:0];
        if (ncap == 4 + A) begin
            dev_a = cap[A-1:0];
            if (cmd == 4'b0100 && dev_a[A-1:A-2] == 2'b11) wen = 1;
        end
        if (cmd == 4'b0101 && ncap == 4 + A + D && wen) mem_arr[dev_a] = cap[D-1:0];
        if (cmd == 4'b0110) begin
            #1;
            if (ncap == 4 + A) mem_miso = 1'b0;
            else if (ncap > 4 + A && ncap <= 4 + A + D) mem_miso = mem_arr[dev_a][4 + A + D - ncap];
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    int pulses, hi_cyc, tail, dich;

    task automatic run_op(input logic [1:0] o, input logic [A-1:0] a, input logic [D-1:0] w);
        logic ps, pd;
        pulses = 0; hi_cyc = 0; tail = 0; dich = 0;
        @(negedge clk);
        req = 1'b1; op = o; addr = a; wdata = w;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R2", "busy after accept", busy, 1);
        ps = mem_clk; pd = mem_mosi;
        while (!done && !timeout) begin
            @(negedge clk);
            if (mem_clk && !ps) pulses++;
            if (mem_clk) hi_cyc++;
            if (mem_clk && ps && mem_mosi != pd) dich++;
            if (busy && !mem_sel && !done) tail++;
            ps = mem_clk; pd = mem_mosi;
        end
        @(negedge clk);
        check(!busy && !done, "R2", "idle after done", {busy, done}, 0);
    endtask

    task automatic common_checks(input int exp_pulses, input int exp_tail);
        check(pulses == exp_pulses, "R3", "rising edge count", pulses, exp_pulses);
        check(hi_cyc == exp_pulses * HALF, "R7", "clock high cycles", hi_cyc, exp_pulses * HALF);
        check(dich == 0, "R7", "data moved while clock high", dich, 0);
        check(tail == exp_tail, "R9", "select-low tail", tail, exp_tail);
    endtask

    task automatic do_write(input logic [A-1:0] a, input logic [D-1:0] w);
        run_op(2'd1, a, w);
        check(fr_n == 4 + A + D, "R4", "write frame length", fr_n, 4 + A + D);
        check(fr_bits[25:0] == {4'b0101, a, w}, "R4", "write frame bits",
              fr_bits[25:0], {4'b0101, a, w});
        common_checks(4 + A + D, SETTLE + WAITC);
    endtask

    task automatic do_read(input logic [A-1:0] a, input logic [D-1:0] exp);
        run_op(2'd0, a, 16'h0);
        check(fr_bits[25:0] == {4'b0110, a, 16'h0}, "R3", "read frame bits",
              fr_bits[25:0], {4'b0110, a, 16'h0});
        common_checks(4 + A + D, SETTLE);
        check(rdata == exp, "R6", "read data", rdata, exp);
    endtask

    task automatic do_enable(input logic [1:0] o);
        run_op(o, 6'h15, 16'h1234);
        check(fr_n == 4 + A, "R5", "enable frame length", fr_n, 4 + A);
        check(fr_bits[9:0] == 10'b0100110000, "R5", "enable frame bits",
              fr_bits[9:0], 10'b0100110000);
        common_checks(4 + A, SETTLE);
    endtask

    function automatic logic [D-1:0] pat(input int a);
        return D'(a * 16'h1357) ^ 16'hA5C3;
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) mem_arr[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        check({mem_sel, mem_clk, mem_mosi, busy, done} == 5'b0, "R1", "outputs in reset",
              {mem_sel, mem_clk, mem_mosi, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({mem_sel, mem_clk, mem_mosi, busy, done} == 5'b0, "R1", "outputs after reset",
              {mem_sel, mem_clk, mem_mosi, busy, done}, 0);
        // R8: select stays low while idle
        check(!mem_sel, "R8", "idle select", mem_sel, 0);

        do_enable(2'd2);
        for (int a = 0; a < 64; a++) do_write(A'(a), pat(a));
        for (int a = 0; a < 64; a++) do_read(A'(a), pat(a));
        do_enable(2'd3);
        do_write(6'd63, 16'hFFFF);
        do_write(6'd0, 16'h0000);
        do_write(6'd21, 16'h8001);
        do_read(6'd63, 16'hFFFF);
        do_read(6'd0, 16'h0000);
        do_read(6'd21, 16'h8001);
        do_read(6'd22, pat(22));

        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait (cyc >= LIMIT);
        if (!ended) begin
            ended = 1;
            timeout = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule